// File: doc/BRIEF.md
# Single-Accumulator Processor with Micro-Step Sequencing

This block is a small processor built around one 16-bit accumulator. It runs one instruction at a time, and each instruction is a fixed series of register transfers. One transfer happens per clock. The transfers move data between a 12-bit program counter, a memory address register, a memory buffer register, a 16-bit instruction register and the accumulator. Instructions and data share one synchronous, word-addressed memory. That memory sits outside the block and returns read data on the clock after the address and read strobe are presented.

An instruction word has two fields. Bits 15:12 hold the opcode. Bits 11:0 hold either a memory address or an I/O device number. There are five opcodes:

- Load the accumulator from memory.
- Store the accumulator to memory.
- Add a memory word to the accumulator.
- Read a numbered device port into the accumulator.
- Write the accumulator to a numbered device port.

Any other opcode stops the processor, and it raises `halt` until the next reset. Integrators connect the memory port and the device-port bus, place a program at the start address, and release reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, `halt`, `mem_we`, `io_rd` and `io_wr` are low. In the first cycle after release, `mem_rd` is high and `mem_addr` equals `START_ADDR` (default 0x300).
- R2: Every instruction begins with a three-cycle fetch:
  - cycle 1 reads memory at the program counter;
  - cycle 2 captures the word while the program counter advances by one;
  - cycle 3 moves the word into the instruction register.
- R3: The opcode is bits 15:12 of the instruction word. The operand (memory address or device number) is bits 11:0.
- R4: Load (opcode 1) reads memory at the operand address in cycle 4. The accumulator then holds that word. The instruction takes 6 cycles.
- R5: Store (opcode 2) raises `mem_we` for exactly one cycle, in cycle 6, with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator. A stored word is what a later fetch of that address returns.
- R6: Add (opcode 5) reads memory at the operand in cycle 4 and adds the word to the accumulator modulo 2^16, with no carry kept. The instruction takes 6 cycles.
- R7: Input (opcode 3) raises `io_rd` for one cycle, in cycle 4, with `io_dev` equal to the operand. The accumulator takes `io_rdata` sampled in that same cycle. The instruction takes 4 cycles.
- R8: Output (opcode 7) raises `io_wr` for one cycle, in cycle 4, with `io_dev` equal to the operand and `io_wdata` equal to the accumulator. The instruction takes 4 cycles.
- R9: Any other opcode (0, 4, 6, 8 to 15) sets `halt` from the cycle after cycle 4. `halt` then stays high, with no memory or port strobe, until reset.
- R10: At most one of `mem_rd`, `mem_we`, `io_rd`, `io_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW (12) | Memory word address |
| mem_rd | output | 1 | Memory read request; data expected on the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW (16) | Memory write data |
| mem_rdata | input | DW (16) | Memory read data |
| io_dev | output | AW (12) | Device port number |
| io_rd | output | 1 | One-cycle device read strobe |
| io_wr | output | 1 | One-cycle device write strobe |
| io_wdata | output | DW (16) | Data written to the device port |
| io_rdata | input | DW (16) | Device data, sampled during `io_rd` |
| halt | output | 1 | Processor stopped on an undefined opcode |

## Verification
Two functions can land back to back on the same memory word:

- the write phase of a store;
- the fetch of the very next instruction.

The bench provokes this with a store whose target is the address of the instruction that follows it. That instruction's original content differs from the stored value, so the next fetch must return the freshly written word. The bench judges the result by the I/O write strobe, device number and data that the rewritten instruction produces. It also checks the memory word left behind afterwards.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPW-1:0] OPC_STORE = 4'h2;
    localparam logic [OPW-1:0] OPC_IN    = 4'h3;
    localparam logic [OPW-1:0] OPC_ADD   = 4'h5;
    localparam logic [OPW-1:0] OPC_OUT   = 4'h7;

    typedef enum logic [2:0] {
        ST_F_MAR,
        ST_F_MBR,
        ST_F_IR,
        ST_X_ADR,
        ST_X_MBR,
        ST_X_FIN,
        ST_HALT
    } step_e;

    // One flag per register transfer or strobe for the current micro-step
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic pc_inc;
        logic ir_from_mbr;
        logic ac_from_mbr;
        logic ac_add;
        logic mem_rd;
        logic mem_we;
        logic io_rd;
        logic io_wr;
    } ctrl_t;

    function automatic logic op_reads_mem(input logic [OPW-1:0] op);
        return (op == OPC_LOAD) || (op == OPC_ADD);
    endfunction

    function automatic logic op_uses_mem(input logic [OPW-1:0] op);
        return op_reads_mem(op) || (op == OPC_STORE);
    endfunction

endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum
);
    // Wraps modulo 2^DW; the carry out is dropped on purpose
    assign sum = a + b;
endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
    import acc_cpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    output ctrl_t          ctrl,
    output logic           halted
);
    step_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_F_MAR;
        else     state <= state_nx;
    end

    always_comb begin
        ctrl     = '0;
        state_nx = state;
        unique case (state)
            ST_F_MAR: begin
                ctrl.mar_from_pc = 1'b1;
                ctrl.mem_rd      = 1'b1;
                state_nx         = ST_F_MBR;
            end
            ST_F_MBR: begin
                ctrl.mbr_from_mem = 1'b1;
                ctrl.pc_inc       = 1'b1;
                state_nx          = ST_F_IR;
            end
            ST_F_IR: begin
                ctrl.ir_from_mbr = 1'b1;
                state_nx         = ST_X_ADR;
            end
            ST_X_ADR: begin
                if (op_uses_mem(opcode)) begin
                    ctrl.mar_from_ir = 1'b1;
                    ctrl.mem_rd      = op_reads_mem(opcode);
                    state_nx         = ST_X_MBR;
                end else if (opcode == OPC_IN) begin
                    ctrl.io_rd = 1'b1;
                    state_nx   = ST_F_MAR;
                end else if (opcode == OPC_OUT) begin
                    ctrl.io_wr = 1'b1;
                    state_nx   = ST_F_MAR;
                end else begin
                    state_nx = ST_HALT;
                end
            end
            ST_X_MBR: begin
                if (opcode == OPC_STORE) ctrl.mbr_from_ac  = 1'b1;
                else                     ctrl.mbr_from_mem = 1'b1;
                state_nx = ST_X_FIN;
            end
            ST_X_FIN: begin
                if (opcode == OPC_LOAD)       ctrl.ac_from_mbr = 1'b1;
                else if (opcode == OPC_ADD)   ctrl.ac_add      = 1'b1;
                else                          ctrl.mem_we      = 1'b1;
                state_nx = ST_F_MAR;
            end
            default: state_nx = ST_HALT;
        endcase
    end

    assign halted = (state == ST_HALT);

    // R2: instruction register load is always followed by the first execute step
    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl.ir_from_mbr |=> (state == ST_X_ADR));

    // R9: once stopped, stays stopped until reset
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R7: device read strobe never lasts more than one cycle
    assert_io_rd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.io_rd |=> !ctrl.io_rd);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_cpu_pkg::*;
#(
    parameter int          AW         = 12,
    parameter int          DW         = 16,
    parameter int unsigned START_ADDR = 'h300
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctrl,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [DW-1:0]  io_rdata,
    output logic [OPW-1:0] opcode,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_we,
    output logic [DW-1:0]  mem_wdata,
    output logic [AW-1:0]  io_dev,
    output logic           io_rd,
    output logic           io_wr,
    output logic [DW-1:0]  io_wdata
);
    localparam logic [AW-1:0] PC_RST = AW'(START_ADDR);

    logic [AW-1:0] pc, mar;
    logic [DW-1:0] mbr, ir, ac, ac_sum;
    logic [AW-1:0] operand;

    assign operand = ir[AW-1:0];
    assign opcode  = ir[DW-1 -: OPW];

    acc_adder #(.DW(DW)) i_add (
        .a   (ac),
        .b   (mbr),
        .sum (ac_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= PC_RST;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            ac  <= '0;
        end else begin
            if (ctrl.mar_from_pc)       mar <= pc;
            else if (ctrl.mar_from_ir)  mar <= operand;
            if (ctrl.pc_inc)            pc  <= pc + AW'(1);
            if (ctrl.mbr_from_mem)      mbr <= mem_rdata;
            else if (ctrl.mbr_from_ac)  mbr <= ac;
            if (ctrl.ir_from_mbr)       ir  <= mbr;
            if (ctrl.ac_from_mbr)       ac  <= mbr;
            else if (ctrl.ac_add)       ac  <= ac_sum;
            else if (ctrl.io_rd)        ac  <= io_rdata;
        end
    end

    // The address leaves with the value MAR is taking, so the synchronous
    // memory answers in the following micro-step
    always_comb begin
        if (ctrl.mar_from_pc)      mem_addr = pc;
        else if (ctrl.mar_from_ir) mem_addr = operand;
        else                       mem_addr = mar;
    end

    assign mem_rd    = ctrl.mem_rd;
    assign mem_we    = ctrl.mem_we;
    assign mem_wdata = mbr;
    assign io_dev    = operand;
    assign io_rd     = ctrl.io_rd;
    assign io_wr     = ctrl.io_wr;
    assign io_wdata  = ac;

    // R2: program counter advances by exactly one per fetch
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl.pc_inc |=> (pc == $past(pc) + AW'(1)));

    // R5: the buffered copy written to memory still matches the accumulator
    assert_store_copy_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_we |-> (mbr == ac));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int          AW         = 12,
    parameter int          DW         = 16,
    parameter int unsigned START_ADDR = 'h300
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] io_dev,
    output logic          io_rd,
    output logic          io_wr,
    output logic [DW-1:0] io_wdata,
    input  logic [DW-1:0] io_rdata,
    output logic          halt
);
    ctrl_t          ctrl;
    logic [OPW-1:0] opcode;

    acc_sequencer i_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .ctrl   (ctrl),
        .halted (halt)
    );

    acc_datapath #(
        .AW         (AW),
        .DW         (DW),
        .START_ADDR (START_ADDR)
    ) i_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .io_rdata  (io_rdata),
        .opcode    (opcode),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .io_dev    (io_dev),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata)
    );

    // R10: strobes are mutually exclusive
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_rd, mem_we, io_rd, io_wr}) <= 1);

    // R9: a stopped processor issues no traffic
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        halt |-> !(mem_rd || mem_we || io_rd || io_wr));
endmodule

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
    localparam int CLK_PERIOD = 10;
    localparam int START      = 'h300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr, io_dev;
    logic        mem_rd, mem_we, io_rd, io_wr, halt;
    logic [15:0] mem_wdata, io_wdata, io_rdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem [0:4095];

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_dev(io_dev), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .halt(halt)
    );

    function automatic int dev_value(input int d);
        return (d * 257 + 'h1234) & 'hFFFF;
    endfunction

    // Synchronous memory: data one clock after the read request
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end
    always_comb io_rdata = 16'(dev_value(int'(io_dev)));

    // ---------------- reference model ----------------
    typedef struct {
        bit mrd, mwe, ird, iwr, hlt;
        int addr, wdata, dev, iowd;
        string tag;
    } exp_t;

    exp_t q[$];
    int   mm [0:4095];
    int   mpc, mac;
    bit   mhalt;

    function automatic exp_t blank(input string t);
        exp_t e;
        e.mrd = 0; e.mwe = 0; e.ird = 0; e.iwr = 0; e.hlt = 0;
        e.addr = 0; e.wdata = 0; e.dev = 0; e.iowd = 0; e.tag = t;
        return e;
    endfunction

    task automatic gen_instr();
        exp_t e;
        int w, op, opd;
        if (mhalt) begin
            e = blank("R9"); e.hlt = 1; q.push_back(e);
            return;
        end
        e = blank("R2"); e.mrd = 1; e.addr = mpc; q.push_back(e);
        w   = mm[mpc];
        mpc = (mpc + 1) % 4096;
        q.push_back(blank("R2"));
        q.push_back(blank("R2"));
        op  = (w >> 12) & 'hF;
        opd = w & 'hFFF;
        case (op)
            1, 5: begin
                e = blank(op == 1 ? "R4" : "R6"); e.mrd = 1; e.addr = opd;
                q.push_back(e);          // R3: operand field picks the address
                q.push_back(blank(e.tag));
                q.push_back(blank(e.tag));
                mac = (op == 1) ? mm[opd] : ((mac + mm[opd]) & 'hFFFF);
            end
            2: begin
                q.push_back(blank("R5"));
                q.push_back(blank("R5"));
                e = blank("R5"); e.mwe = 1; e.addr = opd; e.wdata = mac;
                q.push_back(e);
                mm[opd] = mac;
            end
            3: begin
                e = blank("R7"); e.ird = 1; e.dev = opd; q.push_back(e);
                mac = dev_value(opd);
            end
            7: begin
                e = blank("R8"); e.iwr = 1; e.dev = opd; e.iowd = mac;
                q.push_back(e);
            end
            default: begin
                q.push_back(blank("R9"));
                mhalt = 1;
            end
        endcase
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_cycle();
        exp_t e;
        if (q.size() == 0) gen_instr();
        e = q.pop_front();
        chk(e.tag, "halt",   int'(halt),   int'(e.hlt));
        chk(e.tag, "mem_rd", int'(mem_rd), int'(e.mrd));
        chk(e.tag, "mem_we", int'(mem_we), int'(e.mwe));
        chk(e.tag, "io_rd",  int'(io_rd),  int'(e.ird));
        chk(e.tag, "io_wr",  int'(io_wr),  int'(e.iwr));
        chk("R10", "strobe count ok",
            int'($countones({mem_rd, mem_we, io_rd, io_wr}) <= 1), 1);
        if (e.mrd || e.mwe) chk(e.tag, "mem_addr",  int'(mem_addr),  e.addr);
        if (e.mwe)          chk(e.tag, "mem_wdata", int'(mem_wdata), e.wdata);
        if (e.ird || e.iwr) chk(e.tag, "io_dev",    int'(io_dev),    e.dev);
        if (e.iwr)          chk(e.tag, "io_wdata",  int'(io_wdata),  e.iowd);
    endtask

    task automatic poke(input int a, input int v);
        mem[a] = 16'(v);
        mm[a]  = v;
    endtask

    task automatic load_prog(input int x0, input int x1, input int stop_word);
        for (int i = 0; i < 4096; i++) begin mem[i] = '0; mm[i] = 0; end
        poke('h300, 'h1940);   // load  [940]
        poke('h301, 'h5941);   // add   [941]
        poke('h302, 'h2942);   // store [942]
        poke('h303, 'h3005);   // in    dev 5
        poke('h304, 'h5941);   // add   [941]
        poke('h305, 'h7ABC);   // out   dev ABC
        poke('h306, 'h1943);   // load  [943]
        poke('h307, 'h2308);   // store into the next instruction word
        poke('h308, 'hF000);   // overwritten before it is fetched
        poke('h309, stop_word);
        poke('h940, x0);
        poke('h941, x1);
        poke('h943, 'h7123);   // becomes "out dev 123"
    endtask

    task automatic model_reset();
        q.delete();
        mpc = START; mac = 0; mhalt = 0;
    endtask

    task automatic hold_reset(input int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            chk("R1", "halt in reset",  int'(halt),   0);
            chk("R1", "mem_we in reset", int'(mem_we), 0);
            chk("R1", "io strobes in reset", int'(io_rd | io_wr), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "first read after reset", int'(mem_rd), 1);
        chk("R1", "start address", int'(mem_addr), START);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            if (i != 0) begin @(negedge clk); #1; end
            cmp_cycle();
        end
    endtask

    initial begin
        // Phase 1: 0xFFFF + 3 wraps to 2; store-then-fetch of the next word
        load_prog('hFFFF, 'h0003, 'h0000);
        model_reset();
        hold_reset(3);
        run_cycles(64);
        chk("R6", "wrapped sum in memory", int'(mem['h942]), 'h0002);
        chk("R5", "rewritten instruction word", int'(mem['h308]), 'h7123);

        // Phase 2: reset in the middle of an instruction, then a full rerun
        load_prog('h8000, 'h8000, 'h4000);
        model_reset();
        hold_reset(2);
        run_cycles(9);
        @(negedge clk);
        model_reset();
        hold_reset(2);
        run_cycles(64);
        chk("R6", "0x8000+0x8000 wraps to 0", int'(mem['h942]), 'h0000);
        chk("R9", "halt held after stop opcode 4", int'(halt), 1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            misses++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule